// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two binary floating-point operands and returns a rounded result of the same format. Operands arrive on a valid/ready handshake together with an add/subtract select and a two-bit rounding-mode code. Internally the larger-magnitude operand is steered to a fixed lane and the other significand is shifted right to line up with it. Three extra low bits (guard, round, sticky) are kept so that the rounding step sees the exact sum. The significands are then combined. A carry-out is folded back by a one-bit right shift, and cancellation is undone by a leading-zero-count left shift. The result is rounded in the selected direction and packed.

The format is parameterised by exponent and fraction width and defaults to the 32-bit layout: sign in the top bit, an 8-bit biased exponent below it, and a 23-bit fraction in the low bits with an implied leading one. The block sits in a two-stage elastic pipeline. Stage one unpacks, swaps and aligns. Stage two adds, normalises, rounds and holds the result until the consumer takes it. Operands with a zero exponent field are read as zero. Infinities and NaNs are only propagated, never produced by arithmetic beyond overflow.

Top module: `fp_add_sub`

## Requirements
- R1: For finite normal operands, `out_sum` is the sum, rounded to the result format, of the two values. Each value is (-1)^sign x 1.fraction x 2^(exponent-bias), with bias = 2^(EXP_W-1)-1. The sign is the top bit, the exponent field lies below it and the fraction field occupies the low FRAC_W bits.
- R2: With `in_sub` = 1 the result is `in_a` minus `in_b`; with `in_sub` = 0 it is `in_a` plus `in_b`.
- R3: `in_rm` selects the rounding of inexact results: 00 nearest with ties to even significand, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R4: An operand whose exponent is far below the other's (difference greater than the significand width plus two) affects the result only through the sticky bit. It can therefore move a directed rounding by one unit in the last place, but it cannot change a nearest-even result.
- R5: An exact zero sum of finite operands, including zero plus zero, is +0 (all bits zero) in every mode except 01, where it is -0 (only the sign bit set).
- R6: An operand whose exponent field is zero is treated as zero whatever its fraction. A non-zero result whose normalised exponent, before rounding, would fall below 1 is flushed to a zero that carries the result's sign.
- R7: A result whose rounded exponent reaches the all-ones field value becomes infinity (all-ones exponent, zero fraction) with the result's sign, in all four modes.
- R8: If either input is a NaN, or the operation is infinity minus infinity, the output is the canonical NaN: sign 0, all-ones exponent, fraction MSB 1 and the other fraction bits 0. Otherwise an infinite input passes through with its effective sign, where the sign of `in_b` is flipped when `in_sub` = 1.
- R9: An operand is accepted on a rising edge where `in_valid` and `in_ready` are both high. Results leave in acceptance order, two edges after acceptance when not stalled. While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_sum` stays unchanged and the pipeline accepts nothing once both stages are full.
- R10: While `rst_n` is low, `out_valid` is low. A few cycles after release, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take an operand pair |
| in_a | input | 1+EXP_W+FRAC_W | First operand |
| in_b | input | 1+EXP_W+FRAC_W | Second operand |
| in_sub | input | 1 | 1 = subtract `in_b` from `in_a` |
| in_rm | input | 2 | Rounding mode code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | 1+EXP_W+FRAC_W | Rounded result |

## Verification
The bench sweeps every pair of operands in an 8-bit format (4 exponent bits, 3 fraction bits) against an exact integer model. This exercises the corner cases: halfway ties, where a design that rounds ties away from zero breaks ties to even; total cancellation, where a wrong zero sign shows up in mode 01; carry-out on rounding into a new binade, where a missed exponent increment gives a result half as large; and overflow into infinity. Operands with a zeroed exponent and cancellation below the smallest normal are covered, and either would surface as a spurious tiny value if the flush were missing. Directed 32-bit cases cover far alignment, where a lost sticky bit makes the directed modes return the unincremented value, and a stalling consumer, where a register that is not held would drop or reorder results.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_DOWN    = 2'b01,
    RM_UP      = 2'b10,
    RM_ZERO    = 2'b11
  } rmode_e;

  // Increment decision from the last kept bit, the first dropped bit and
  // the OR of everything below it.
  function automatic logic round_up(rmode_e rm, logic sign, logic lsb,
                                    logic guard, logic rest);
    case (rm)
      RM_NEAREST: return guard & (rest | lsb);
      RM_DOWN:    return sign & (guard | rest);
      RM_UP:      return ~sign & (guard | rest);
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fpadd_align.sv
module fpadd_align #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int EXT_W = FRAC_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic             sub,
  output logic [EXP_W-1:0] big_exp,
  output logic [EXT_W-1:0] big_sig,
  output logic [EXT_W-1:0] small_sig,
  output logic             eff_sub,
  output logic             res_sign,
  output logic             spec_nan,
  output logic             spec_inf,
  output logic             spec_sign
);
  localparam int SIG_W  = FRAC_W + 1;
  localparam int LIM    = SIG_W + 3;
  localparam int WIDE_W = SIG_W + LIM + 2;
  localparam int MAG_W  = EXP_W + FRAC_W;

  logic             sa, sb, swap;
  logic             a_nan, b_nan, a_inf, b_inf;
  logic [EXP_W-1:0] ea, eb, le, se;
  logic [MAG_W-1:0] ma, mb, lmag, smag;
  logic [SIG_W-1:0] lsig, ssig;
  logic [31:0]      diff, shamt;
  logic [WIDE_W-1:0] wide;

  always_comb begin
    sa    = in_a[W-1];
    sb    = in_b[W-1] ^ sub;
    ea    = in_a[W-2:FRAC_W];
    eb    = in_b[W-2:FRAC_W];
    a_nan = (&ea) & (|in_a[FRAC_W-1:0]);
    b_nan = (&eb) & (|in_b[FRAC_W-1:0]);
    a_inf = (&ea) & ~(|in_a[FRAC_W-1:0]);
    b_inf = (&eb) & ~(|in_b[FRAC_W-1:0]);
    ma    = (ea == '0) ? '0 : in_a[MAG_W-1:0];
    mb    = (eb == '0) ? '0 : in_b[MAG_W-1:0];
    swap  = (mb > ma);
    lmag  = swap ? mb : ma;
    smag  = swap ? ma : mb;
    le    = lmag[MAG_W-1:FRAC_W];
    se    = smag[MAG_W-1:FRAC_W];
    lsig  = {le != '0, lmag[FRAC_W-1:0]};
    ssig  = {se != '0, smag[FRAC_W-1:0]};
    diff  = 32'(le) - 32'(se);
    shamt = (diff > 32'(LIM)) ? 32'(LIM) : diff;
    wide  = {ssig, {(LIM+2){1'b0}}} >> shamt;
  end

  always_comb begin
    big_exp   = le;
    big_sig   = {lsig, 3'b000};
    small_sig = {wide[WIDE_W-1:LIM], |wide[LIM-1:0]};
    res_sign  = swap ? sb : sa;
    eff_sub   = sa ^ sb;
    spec_nan  = a_nan | b_nan | (a_inf & b_inf & (sa ^ sb));
    spec_inf  = a_inf | b_inf;
    spec_sign = a_inf ? sa : sb;
  end

  // R4
  far_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (diff > 32'(LIM)) |-> (small_sig[EXT_W-1:1] == '0));

endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int EXT_W = FRAC_W + 4,
  localparam int XE_W  = EXP_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [EXP_W-1:0]       big_exp,
  input  logic [EXT_W-1:0]       big_sig,
  input  logic [EXT_W-1:0]       small_sig,
  input  logic                   eff_sub,
  output logic [EXT_W-1:0]       norm_sig,
  output logic signed [XE_W-1:0] norm_exp,
  output logic                   is_zero
);
  localparam int LZ_W = $clog2(EXT_W + 1);

  logic [EXT_W:0]         sum;
  logic [LZ_W-1:0]        lz;
  logic signed [XE_W-1:0] base;

  always_comb begin
    if (eff_sub) sum = {1'b0, big_sig} - {1'b0, small_sig};
    else         sum = {1'b0, big_sig} + {1'b0, small_sig};
  end

  always_comb begin
    lz = LZ_W'(EXT_W);
    for (int i = 0; i < EXT_W; i++) begin
      if (sum[i]) lz = LZ_W'(EXT_W - 1 - i);
    end
  end

  always_comb begin
    base    = $signed({2'b00, big_exp});
    is_zero = (sum == '0);
    if (sum[EXT_W]) begin
      norm_sig = {sum[EXT_W:2], sum[1] | sum[0]};
      norm_exp = base + XE_W'(1);
    end else begin
      norm_sig = sum[EXT_W-1:0] << lz;
      norm_exp = base - $signed({{(XE_W-LZ_W){1'b0}}, lz});
    end
  end

  // R1
  norm_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_zero |-> norm_sig[EXT_W-1]);

endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int EXT_W = FRAC_W + 4,
  localparam int XE_W  = EXP_W + 2
) (
  input  logic [EXT_W-1:0]       norm_sig,
  input  logic signed [XE_W-1:0] norm_exp,
  input  logic                   is_zero,
  input  logic                   sign,
  input  logic [1:0]             rm,
  input  logic                   spec_nan,
  input  logic                   spec_inf,
  input  logic                   spec_sign,
  output logic [W-1:0]           result
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int EMAX  = (1 << EXP_W) - 1;

  logic                   up;
  logic [SIG_W:0]         rsig;
  logic signed [XE_W-1:0] rexp;

  always_comb begin
    up   = round_up(rmode_e'(rm), sign, norm_sig[3], norm_sig[2], |norm_sig[1:0]);
    rsig = {1'b0, norm_sig[EXT_W-1:3]} + (SIG_W+1)'(up);
    rexp = norm_exp + $signed({{(XE_W-1){1'b0}}, rsig[SIG_W]});
  end

  always_comb begin
    if (spec_nan)
      result = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    else if (spec_inf)
      result = {spec_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (is_zero)
      result = {rm == RM_DOWN, {(W-1){1'b0}}};
    else if (int'(norm_exp) <= 0)
      result = {sign, {(W-1){1'b0}}};
    else if (int'(rexp) >= EMAX)
      result = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else
      result = {sign, rexp[EXP_W-1:0], rsig[FRAC_W-1:0]};
  end

endmodule

// File: rtl/fp_add_sub.sv
module fp_add_sub #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [EXP_W+FRAC_W:0]   in_a,
  input  logic [EXP_W+FRAC_W:0]   in_b,
  input  logic                    in_sub,
  input  logic [1:0]              in_rm,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [EXP_W+FRAC_W:0]   out_sum
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int EXT_W = FRAC_W + 4;
  localparam int XE_W  = EXP_W + 2;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_l = rst_sync[1];

  // stage-one combinational outputs
  logic [EXP_W-1:0] a_exp;
  logic [EXT_W-1:0] a_big, a_small;
  logic a_effsub, a_sign, a_nan, a_inf, a_isign;

  fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .clk(clk), .rst_n(rst_l), .in_a(in_a), .in_b(in_b), .sub(in_sub),
    .big_exp(a_exp), .big_sig(a_big), .small_sig(a_small), .eff_sub(a_effsub),
    .res_sign(a_sign), .spec_nan(a_nan), .spec_inf(a_inf), .spec_sign(a_isign));

  // stage-one registers
  logic [EXP_W-1:0] s1_exp;
  logic [EXT_W-1:0] s1_big, s1_small;
  logic s1_effsub, s1_sign, s1_nan, s1_inf, s1_isign;
  logic [1:0] s1_rm;
  logic s1_v, s1_v_n, s2_v, s2_v_n, s1_en, s2_en, take;
  logic [W-1:0] s2_q, r_sum;

  // stage-two combinational path
  logic [EXT_W-1:0]       n_sig;
  logic signed [XE_W-1:0] n_exp;
  logic                   n_zero;

  fpadd_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .clk(clk), .rst_n(rst_l), .big_exp(s1_exp), .big_sig(s1_big),
    .small_sig(s1_small), .eff_sub(s1_effsub),
    .norm_sig(n_sig), .norm_exp(n_exp), .is_zero(n_zero));

  fpadd_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .norm_sig(n_sig), .norm_exp(n_exp), .is_zero(n_zero), .sign(s1_sign),
    .rm(s1_rm), .spec_nan(s1_nan), .spec_inf(s1_inf), .spec_sign(s1_isign),
    .result(r_sum));

  // handshake next state
  always_comb begin
    s2_en    = !s2_v || out_ready;
    s1_en    = !s1_v || s2_en;
    in_ready = s1_en && rst_l;
    take     = in_valid && in_ready;
    s1_v_n   = s1_en ? take : s1_v;
    s2_v_n   = s2_en ? s1_v : s2_v;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      s1_v <= s1_v_n;
      s2_v <= s2_v_n;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      s1_exp    <= a_exp;
      s1_big    <= a_big;
      s1_small  <= a_small;
      s1_effsub <= a_effsub;
      s1_sign   <= a_sign;
      s1_nan    <= a_nan;
      s1_inf    <= a_inf;
      s1_isign  <= a_isign;
      s1_rm     <= in_rm;
    end
    if (s2_en && s1_v) s2_q <= r_sum;
  end

  assign out_valid = s2_v;
  assign out_sum   = s2_q;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

  // R9
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (out_valid && !out_ready && s1_v) |-> !in_ready);

  // R8
  nan_canon_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (out_valid && (&out_sum[W-2:FRAC_W]) && (|out_sum[FRAC_W-1:0])) |-> (out_sum == QNAN));

endmodule

// File: tb/sim_fp_add_sub.sv
`timescale 1ns/1ps
module sim_fp_add_sub;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // small format instance: 4 exponent bits, 3 fraction bits
  logic       v0, r0, ov0, or0, sub0;
  logic [1:0] rm0;
  logic [7:0] a0, b0, s0;

  fp_add_sub #(.EXP_W(4), .FRAC_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(v0), .in_ready(r0), .in_a(a0), .in_b(b0),
    .in_sub(sub0), .in_rm(rm0), .out_valid(ov0), .out_ready(or0), .out_sum(s0));

  // default 32-bit instance
  logic        v1, r1, ov1, sub1;
  logic [1:0]  rm1;
  logic [31:0] a1, b1, s1;

  fp_add_sub u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_ready(r1), .in_a(a1), .in_b(b1),
    .in_sub(sub1), .in_rm(rm1), .out_valid(ov1), .out_ready(1'b1), .out_sum(s1));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // exact model of the 8-bit format, bias 7, values scaled by 2^9
  function automatic logic [7:0] ref8(input logic [7:0] a, input logic [7:0] b,
                                      input logic sub, input logic [1:0] rm);
    logic sa, sb, neg, up;
    int ea, eb, fa, fb, va, vb, s, m, p, e, sh, q, rem, half;
    sa = a[7]; sb = b[7] ^ sub;
    ea = int'(a[6:3]); eb = int'(b[6:3]); fa = int'(a[2:0]); fb = int'(b[2:0]);
    if ((ea == 15 && fa != 0) || (eb == 15 && fb != 0)) return 8'h7C;
    if (ea == 15 && eb == 15 && sa != sb) return 8'h7C;
    if (ea == 15) return {sa, 7'h78};
    if (eb == 15) return {sb, 7'h78};
    va = (ea == 0) ? 0 : ((8 + fa) << (ea - 1));
    vb = (eb == 0) ? 0 : ((8 + fb) << (eb - 1));
    if (sa) va = -va;
    if (sb) vb = -vb;
    s = va + vb;
    if (s == 0) return {rm == 2'b01, 7'h00};
    neg = (s < 0);
    m = neg ? -s : s;
    p = 0;
    for (int k = 0; k < 31; k++) if (((m >> k) & 1) == 1) p = k;
    e = p - 2;
    if (e < 1) return {neg, 7'h00};
    sh = p - 3;
    q = m >> sh;
    rem = m & ((1 << sh) - 1);
    up = 1'b0;
    if (sh > 0) begin
      half = 1 << (sh - 1);
      case (rm)
        2'b00: up = (rem > half) || (rem == half && (q & 1) == 1);
        2'b01: up = neg && rem != 0;
        2'b10: up = !neg && rem != 0;
        default: up = 1'b0;
      endcase
    end
    q = q + int'(up);
    if (q == 16) begin q = 8; e = e + 1; end
    if (e >= 15) return {neg, 7'h78};
    return {neg, 4'(e), 3'(q)};
  endfunction

  function automatic string tag8(input logic [7:0] a, input logic [7:0] b,
                                 input logic sub, input logic [7:0] exp);
    if (&a[6:3] || &b[6:3]) return "R8";
    if (a[6:3] == 4'd0 || b[6:3] == 4'd0) return "R6";
    if (exp[6:3] == 4'hF) return "R7";
    if (exp[6:0] == 7'd0) return "R5/R6";
    if (sub) return "R2/R3";
    return "R1/R3";
  endfunction

  // one 32-bit operation with latency check
  task automatic run32(input logic [31:0] a, input logic [31:0] b, input logic sub,
                       input logic [1:0] rm, input logic [31:0] exp, input string req);
    @(negedge clk);
    a1 = a; b1 = b; sub1 = sub; rm1 = rm; v1 = 1'b1;
    #1;
    check(r1 == 1'b1, "R9 in_ready", 32'(r1), 32'd1);
    @(negedge clk);
    v1 = 1'b0;
    check(ov1 == 1'b0, "R9 latency first edge", 32'(ov1), 32'd0);
    @(negedge clk);
    check(ov1 == 1'b1, "R9 latency second edge", 32'(ov1), 32'd1);
    check(s1 == exp, req, s1, exp);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog: actual=run not complete expected=finish within limit");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  exp_q[$];
    logic [23:0] in_q[$];
    logic [15:0] lf;
    logic [7:0]  held;
    logic [7:0]  e8;
    logic [23:0] iv;
    bit          stalled;
    int          idx;

    v0 = 1'b0; or0 = 1'b0; sub0 = 1'b0; rm0 = 2'b00; a0 = '0; b0 = '0;
    v1 = 1'b0; sub1 = 1'b0; rm1 = 2'b00; a1 = '0; b1 = '0;

    // R10: outputs idle while reset is held
    repeat (2) @(negedge clk);
    check(ov0 == 1'b0, "R10 out_valid in reset u0", 32'(ov0), 32'd0);
    check(ov1 == 1'b0, "R10 out_valid in reset u1", 32'(ov1), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(r0 == 1'b1, "R10 in_ready after release", 32'(r0), 32'd1);
    check(ov0 == 1'b0, "R10 out_valid after release", 32'(ov0), 32'd0);

    // directed 32-bit cases
    run32(32'h42168000, 32'h40768000, 1'b0, 2'b00, 32'h4225E800, "R1 worked sum");
    run32(32'h3F800000, 32'h3F800000, 1'b0, 2'b00, 32'h40000000, "R1 carry out");
    run32(32'h412C0000, 32'h3F400000, 1'b1, 2'b00, 32'h41200000, "R2 subtract");
    run32(32'h3F800000, 32'h30800000, 1'b0, 2'b10, 32'h3F800001, "R4 far operand up");
    run32(32'h3F800000, 32'h30800000, 1'b0, 2'b00, 32'h3F800000, "R4 far operand nearest");
    run32(32'h3F800000, 32'h30800000, 1'b1, 2'b01, 32'h3F7FFFFF, "R3/R4 far sub down");
    run32(32'h3F800000, 32'h30800000, 1'b1, 2'b11, 32'h3F7FFFFF, "R3 far sub to zero");
    run32(32'h3F800000, 32'h30800000, 1'b1, 2'b10, 32'h3F800000, "R3 far sub up");
    run32(32'h3F800000, 32'h3F800000, 1'b1, 2'b01, 32'h80000000, "R5 zero mode 01");
    run32(32'h3F800000, 32'h3F800000, 1'b1, 2'b00, 32'h00000000, "R5 zero mode 00");
    run32(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 2'b11, 32'h7F800000, "R7 overflow");
    run32(32'h7F800000, 32'h7F800000, 1'b1, 2'b00, 32'h7FC00000, "R8 inf minus inf");
    run32(32'h00000001, 32'h3F800000, 1'b0, 2'b10, 32'h3F800000, "R6 zero-exponent operand");

    // exhaustive 8-bit sweep with a stalling consumer
    lf = 16'hACE1;
    idx = 0;
    stalled = 1'b0;
    held = '0;
    while (idx < 65536 || exp_q.size() > 0) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      or0 = (lf[1:0] != 2'b00);
      if (idx < 65536) begin
        a0 = idx[15:8];
        b0 = idx[7:0];
        sub0 = idx[10] ^ idx[0] ^ idx[3];
        rm0 = 2'(idx[9:8] + idx[1:0] + idx[5:4]);
        v0 = 1'b1;
      end else begin
        v0 = 1'b0;
      end
      #1;
      if (stalled) begin
        check(ov0 == 1'b1 && s0 == held, "R9 held under stall", {23'd0, ov0, s0}, {24'd1, held});
      end
      stalled = ov0 && !or0;
      held = s0;
      if (ov0 && or0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected result", 32'(s0), 32'd0);
        end else begin
          e8 = exp_q.pop_front();
          iv = in_q.pop_front();
          check(s0 == e8, tag8(iv[23:16], iv[15:8], iv[2], e8), 32'(s0), 32'(e8));
        end
      end
      if (v0 && r0) begin
        exp_q.push_back(ref8(a0, b0, sub0, rm0));
        in_q.push_back({a0, b0, 5'd0, sub0, rm0});
        idx++;
      end
    end
    v0 = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule